// File: doc/BRIEF.md
# Quad-I/O Aligned Burst Read Controller

This block sits on the host side of a serial NOR flash link that uses four data lines. It takes one request at a time from a valid/ready port and turns it into a chip-select framed transaction. A request is either a 16-byte aligned burst read or a command that takes the flash out of continuous-read mode. A read sends an optional single-line command byte (E3h), then a 24-bit address on all four lines, then a mode byte, and captures 32 nibbles of read data with no dummy clocks in between. The bytes are returned on a one-cycle valid/data strobe.

The mode byte tells the flash whether the next transaction may leave out the command byte. The controller remembers what it last sent. After a read that asked for continuous mode (upper mode nibble A), the next read starts directly with the address. After any other read, the next read starts with the command byte again. A mode-reset request drives all four lines high for eight clocks and clears the remembered state. The serial clock runs at half the system clock, idles low, and only toggles while chip select is low.

Top module: `qspi_octword_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, flash_cs_n is 1, flash_sck is 0, io_oe is 4'b0000, rd_valid is 0 and req_ready is 1. The first read after reset always includes the command byte.
- R2: req_ready is 1 only while the controller is idle with flash_cs_n high. A request offered while a transaction or its gap is in progress is not taken and has no effect on the lines.
- R3: A read that is not in continuous mode starts with 8 serial clocks that carry 8'hE3, most significant bit first, on io_out[0], with io_oe = 4'b0001 and io_out[3:1] = 0.
- R4: The address follows on 6 clocks with io_oe = 4'b1111, most significant nibble first on io_out[3:0]. Address bits [3:0] are always sent as zero, whatever the request holds.
- R5: The mode byte follows on 2 clocks. Its upper nibble is 4'hA when req_cont was 1 and 4'h0 otherwise. Its lower nibble is 4'h0. Data clocks start immediately after it.
- R6: io_oe drops to 4'b0000 in the high half of the second mode clock, so the lines are free before the falling edge that starts the first data clock. io_oe stays at 0 until chip select rises.
- R7: A read has 32 data clocks. io_in is sampled at the system edge where flash_sck rises, high nibble first. rd_valid pulses for one cycle, in the high half of every second data clock, with the assembled byte on rd_data. Each read returns exactly 16 bytes.
- R8: flash_sck equals 0 whenever flash_cs_n is 1. While chip select is low, flash_sck alternates every system cycle, starting low. io_out and io_oe change only when flash_sck goes low.
- R9: After a read with req_cont = 1, the next read leaves out the command byte and its first clock carries address bits [23:20]. After a read with req_cont = 0, the next read includes the command byte.
- R10: A request with req_mreset = 1 gives 8 clocks with io_oe = io_out = 4'b1111 and returns no data. The next read then includes the command byte.
- R11: After a transaction, flash_cs_n stays high for at least two system cycles (one serial clock period) before it falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 24 | Read byte address; bits [3:0] are forced to zero |
| req_cont | input | 1 | Ask the flash to stay in continuous-read mode after this read |
| req_mreset | input | 1 | Issue a continuous-mode reset instead of a read |
| rd_valid | output | 1 | One-cycle strobe for a returned byte |
| rd_data | output | 8 | Returned byte |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Serial clock |
| io_out | output | 4 | Values driven onto the four data lines |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Values read back from the four data lines |

## Verification
A wrong continuous-mode flag shows in the first serial clock of the next transaction. The cycle after chip select falls, the bench sees either a single-line command bit with io_oe = 4'b0001 or a four-line address nibble, so the fault is caught within one system cycle. A slip in the shift or phase counters shows on io_out or io_oe in the serial clock where it happens. A slip in capture or the nibble order shows as a wrong rd_data, or a misplaced rd_valid, in the high half of the affected data clock. Late output-enable release or too short a chip-select gap shows at the exact cycle on io_oe or flash_cs_n.

// File: rtl/qowr_pkg.sv
package qowr_pkg;

    localparam int NIB_W      = 4;
    localparam int ADDR_W     = 24;
    localparam int OPC_W      = 8;
    localparam int MODE_W     = 8;
    localparam int ALIGN_BITS = 4;

    localparam logic [OPC_W-1:0] RD_OPCODE = 8'hE3;
    localparam logic [NIB_W-1:0] CONT_KEY  = 4'hA;

    localparam int OPC_CLKS  = OPC_W;
    localparam int ADDR_CLKS = ADDR_W / NIB_W;
    localparam int MODE_CLKS = MODE_W / NIB_W;
    localparam int MRST_CLKS = 8;
    localparam int PAY_W     = ADDR_W + MODE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_MODE,
        PH_DATA,
        PH_MRST,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [NIB_W-1:0] oe;
        logic [NIB_W-1:0] dout;
    } pins_t;

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    function automatic logic [MODE_W-1:0] mode_byte(input logic cont);
        return {(cont ? CONT_KEY : {NIB_W{1'b0}}), {(MODE_W-NIB_W){1'b0}}};
    endfunction

endpackage

// File: rtl/qowr_seq.sv
module qowr_seq
    import qowr_pkg::*;
#(
    parameter int DATA_CLKS = 32,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_cont,
    input  logic             req_mreset,
    output logic             req_ready,
    output logic             load,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             half,
    output logic             cs_n,
    output logic             sck
);

    logic cont_q;     // flash currently expects no command byte
    logic cont_pend;  // value to adopt once the running read completes

    function automatic logic [CNT_W-1:0] last_of(input phase_e p);
        case (p)
            PH_OPC:  return CNT_W'(OPC_CLKS - 1);
            PH_ADDR: return CNT_W'(ADDR_CLKS - 1);
            PH_MODE: return CNT_W'(MODE_CLKS - 1);
            PH_DATA: return CNT_W'(DATA_CLKS - 1);
            PH_MRST: return CNT_W'(MRST_CLKS - 1);
            default: return '0;
        endcase
    endfunction

    function automatic phase_e next_of(input phase_e p);
        case (p)
            PH_OPC:  return PH_ADDR;
            PH_ADDR: return PH_MODE;
            PH_MODE: return PH_DATA;
            default: return PH_GAP;
        endcase
    endfunction

    assign req_ready = (phase == PH_IDLE);
    assign load      = req_ready && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            half      <= 1'b0;
            cs_n      <= 1'b1;
            sck       <= 1'b0;
            cont_q    <= 1'b0;
            cont_pend <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cs_n      <= 1'b0;
                        cnt       <= '0;
                        half      <= 1'b0;
                        cont_pend <= req_cont;
                        if (req_mreset)
                            phase <= PH_MRST;
                        else if (cont_q)
                            phase <= PH_ADDR;
                        else
                            phase <= PH_OPC;
                    end
                end
                PH_GAP: begin
                    phase <= PH_IDLE;
                end
                default: begin
                    if (!half) begin
                        half <= 1'b1;
                        sck  <= 1'b1;
                    end else begin
                        half <= 1'b0;
                        sck  <= 1'b0;
                        if (cnt == last_of(phase)) begin
                            cnt   <= '0;
                            phase <= next_of(phase);
                            if (phase == PH_DATA) begin
                                cs_n   <= 1'b1;
                                cont_q <= cont_pend;
                            end else if (phase == PH_MRST) begin
                                cs_n   <= 1'b1;
                                cont_q <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/qowr_txpath.sv
module qowr_txpath
    import qowr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cont,
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              half,
    output logic [NIB_W-1:0]  io_out,
    output logic [NIB_W-1:0]  io_oe
);

    logic [OPC_W-1:0] opc_sr;
    logic [PAY_W-1:0] pay_sr;
    pins_t            pins;
    logic             mode_tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_sr <= '0;
            pay_sr <= '0;
        end else if (load) begin
            opc_sr <= RD_OPCODE;
            pay_sr <= {align_addr(req_addr), mode_byte(req_cont)};
        end else if (half) begin
            if (phase == PH_OPC)
                opc_sr <= opc_sr << 1;
            if (phase == PH_ADDR || phase == PH_MODE)
                pay_sr <= pay_sr << NIB_W;
        end
    end

    // high half of the final mode clock: lines handed back to the flash
    assign mode_tail = (phase == PH_MODE) && half && (cnt == CNT_W'(MODE_CLKS - 1));

    always_comb begin
        pins = '0;
        case (phase)
            PH_OPC: begin
                pins.oe   = {{(NIB_W-1){1'b0}}, 1'b1};
                pins.dout = {{(NIB_W-1){1'b0}}, opc_sr[OPC_W-1]};
            end
            PH_ADDR, PH_MODE: begin
                if (!mode_tail) begin
                    pins.oe   = {NIB_W{1'b1}};
                    pins.dout = pay_sr[PAY_W-1 -: NIB_W];
                end
            end
            PH_MRST: begin
                pins.oe   = {NIB_W{1'b1}};
                pins.dout = {NIB_W{1'b1}};
            end
            default: pins = '0;
        endcase
    end

    assign io_out = pins.dout;
    assign io_oe  = pins.oe;

endmodule

// File: rtl/qowr_rxpath.sv
module qowr_rxpath
    import qowr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             cnt_lsb,
    input  logic             half,
    input  logic [NIB_W-1:0] io_in,
    output logic             rd_valid,
    output logic [2*NIB_W-1:0] rd_data
);

    logic [NIB_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            // this edge raises the serial clock: sample now
            if (phase == PH_DATA && !half) begin
                if (!cnt_lsb) begin
                    hi_q <= io_in;
                end else begin
                    rd_data  <= {hi_q, io_in};
                    rd_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qspi_octword_reader.sv
module qspi_octword_reader
    import qowr_pkg::*;
#(
    parameter int BURST_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [23:0] req_addr,
    input  logic        req_cont,
    input  logic        req_mreset,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        flash_cs_n,
    output logic        flash_sck,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in
);

    localparam int DATA_CLKS = 2 * BURST_BYTES;
    localparam int MAX_CLKS  = (DATA_CLKS > OPC_CLKS) ? DATA_CLKS : OPC_CLKS;
    localparam int CNT_W     = $clog2(MAX_CLKS);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             half;
    logic             load;

    qowr_seq #(
        .DATA_CLKS (DATA_CLKS),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_cont   (req_cont),
        .req_mreset (req_mreset),
        .req_ready  (req_ready),
        .load       (load),
        .phase      (phase),
        .cnt        (cnt),
        .half       (half),
        .cs_n       (flash_cs_n),
        .sck        (flash_sck)
    );

    qowr_txpath #(
        .CNT_W (CNT_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .req_addr (req_addr),
        .req_cont (req_cont),
        .phase    (phase),
        .cnt      (cnt),
        .half     (half),
        .io_out   (io_out),
        .io_oe    (io_oe)
    );

    qowr_rxpath u_rx (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cnt_lsb  (cnt[0]),
        .half     (half),
        .io_in    (io_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/qspi_octword_reader_chk.sv
module qspi_octword_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       flash_cs_n,
    input logic       flash_sck,
    input logic       req_ready,
    input logic       rd_valid,
    input logic [3:0] io_oe,
    input logic [3:0] io_out
);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !flash_cs_n |-> !req_ready);

    assert_single_lane_R3: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 4'b0001) |-> (io_out[3:1] == 3'b000));

    assert_lines_free_when_deselected_R6: assert property (@(posedge clk) disable iff (rst)
        flash_cs_n |-> (io_oe == 4'b0000));

    assert_strobe_in_high_half_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (flash_sck && !flash_cs_n && io_oe == 4'b0000));

    assert_strobe_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_sck_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        flash_cs_n |-> !flash_sck);

    assert_sck_alternates_R8: assert property (@(posedge clk) disable iff (rst)
        (!flash_cs_n && !$past(flash_cs_n)) |-> (flash_sck != $past(flash_sck)));

    assert_drive_holds_in_high_R8: assert property (@(posedge clk) disable iff (rst)
        (flash_sck && io_oe != 4'b0000) |-> ($stable(io_out) && $stable(io_oe)));

    assert_cs_gap_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(flash_cs_n) |=> flash_cs_n);

endmodule

bind qspi_octword_reader qspi_octword_reader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .flash_cs_n (flash_cs_n),
    .flash_sck  (flash_sck),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .io_oe      (io_oe),
    .io_out     (io_out)
);

// File: tb/qspi_octword_reader_tb_top.sv
`timescale 1ns/1ps
module qspi_octword_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_cont = 1'b0;
    logic        req_mreset = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        flash_cs_n;
    logic        flash_sck;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic [3:0]  io_in = 4'h0;

    int checks = 0;
    int errors = 0;
    bit cont_ref = 1'b0;
    bit done = 1'b0;

    localparam logic [7:0] OPC_REF = 8'hE3;

    always #2.5 clk = ~clk;

    qspi_octword_reader dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_cont   (req_cont),
        .req_mreset (req_mreset),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .flash_cs_n (flash_cs_n),
        .flash_sck  (flash_sck),
        .io_out     (io_out),
        .io_oe      (io_oe),
        .io_in      (io_in)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_lines(input string tag, input logic cs, input logic sck,
                             input logic [3:0] oe, input logic [3:0] dout,
                             input logic rdy, input logic rdv);
        chk(flash_cs_n == cs && flash_sck == sck, "R8", "cs/sck",
            {30'd0, flash_cs_n, flash_sck}, {30'd0, cs, sck});
        chk(io_oe == oe && io_out == dout, tag, "oe/out",
            {24'd0, io_oe, io_out}, {24'd0, oe, dout});
        chk(req_ready == rdy, "R2", "ready", {31'd0, req_ready}, {31'd0, rdy});
        chk(rd_valid == rdv, "R7", "rd_valid", {31'd0, rd_valid}, {31'd0, rdv});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cycles(input int n, input string tag);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk_lines(tag, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0);
            step();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_lines("R1", 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0);
        rst = 1'b0;
        cont_ref = 1'b0;
        step();
        chk_lines("R1", 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0);
    endtask

    // Called at the falling clock edge of an idle cycle; returns at the falling
    // edge of the first idle cycle after the gap. req_valid stays high with
    // unrelated fields during the transaction to probe hold-off.
    task automatic run_txn(input bit mr, input logic [23:0] a, input bit c,
                           input logic [7:0] seed, input string first_tag);
        logic [3:0] eo [64];
        logic [3:0] ev [64];
        logic [3:0] di [64];
        string      tg [64];
        bit         isdata [64];
        logic [23:0] al;
        logic [7:0]  md;
        logic [7:0]  bval;
        int n;
        int mlast;
        int dstart;
        int nbytes;
        al = {a[23:4], 4'h0};
        md = {(c ? 4'hA : 4'h0), 4'h0};
        n = 0;
        mlast = -1;
        dstart = 64;
        if (mr) begin
            for (int i = 0; i < 8; i++) begin
                eo[n] = 4'hF; ev[n] = 4'hF; di[n] = 4'h0; tg[n] = "R10"; isdata[n] = 1'b0; n++;
            end
        end else begin
            if (!cont_ref) begin
                for (int i = 0; i < 8; i++) begin
                    eo[n] = 4'h1; ev[n] = {3'b000, OPC_REF[7-i]}; di[n] = 4'h0;
                    tg[n] = "R3"; isdata[n] = 1'b0; n++;
                end
            end
            for (int i = 0; i < 6; i++) begin
                eo[n] = 4'hF; ev[n] = al[23-4*i -: 4]; di[n] = 4'h0;
                tg[n] = "R4"; isdata[n] = 1'b0; n++;
            end
            for (int i = 0; i < 2; i++) begin
                eo[n] = 4'hF; ev[n] = md[7-4*i -: 4]; di[n] = 4'h0;
                tg[n] = "R5"; isdata[n] = 1'b0; n++;
            end
            mlast = n - 1;
            dstart = n;
            for (int i = 0; i < 32; i++) begin
                bval = seed + 8'(29 * (i / 2));
                eo[n] = 4'h0; ev[n] = 4'h0;
                di[n] = (i % 2 == 0) ? bval[7:4] : bval[3:0];
                tg[n] = "R7"; isdata[n] = 1'b1; n++;
            end
        end
        tg[0] = first_tag;

        chk_lines("R11", 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0);
        req_valid  = 1'b1;
        req_addr   = a;
        req_cont   = c;
        req_mreset = mr;
        step();
        // hold-off probe: a different request stays offered
        req_addr   = ~a;
        req_cont   = ~c;
        req_mreset = 1'b1;
        nbytes = 0;
        for (int k = 0; k < n; k++) begin
            io_in = di[k];
            chk_lines(tg[k], 1'b0, 1'b0, eo[k], ev[k], 1'b0, 1'b0);
            step();
            if (k == mlast)
                chk_lines("R6", 1'b0, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0);
            else
                chk_lines(tg[k], 1'b0, 1'b1, eo[k], ev[k], 1'b0,
                          isdata[k] && ((k - dstart) % 2 == 1));
            if (isdata[k] && ((k - dstart) % 2 == 1)) begin
                bval = seed + 8'(29 * ((k - dstart) / 2));
                chk(rd_data == bval, "R7", "rd_data", {24'd0, rd_data}, {24'd0, bval});
                if (rd_valid) nbytes++;
            end
            step();
        end
        io_in = 4'h0;
        chk_lines("R11", 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0);
        chk(nbytes == (mr ? 0 : 16), mr ? "R10" : "R7", "byte count", nbytes, mr ? 0 : 16);
        cont_ref = mr ? 1'b0 : c;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();                                            // R1
        idle_cycles(3, "R2");
        run_txn(1'b0, 24'h123450, 1'b0, 8'h11, "R3");          // plain read
        run_txn(1'b0, 24'hABCDEF, 1'b1, 8'h5C, "R4");          // unaligned, asks for continuous
        run_txn(1'b0, 24'h00FFF8, 1'b1, 8'hE0, "R9");          // no command byte
        run_txn(1'b0, 24'h7F0013, 1'b0, 8'h3A, "R9");          // still skipped, leaves continuous
        run_txn(1'b0, 24'hFFFFFF, 1'b0, 8'h9D, "R9");          // command byte is back
        idle_cycles(2, "R2");
        run_txn(1'b0, 24'h000000, 1'b1, 8'h00, "R5");
        run_txn(1'b1, 24'h555555, 1'b1, 8'h00, "R10");         // mode reset
        run_txn(1'b0, 24'h246800, 1'b1, 8'hC7, "R10");         // command byte after mode reset
        do_reset();                                            // clears continuous state
        run_txn(1'b0, 24'h13579B, 1'b0, 8'h42, "R1");          // command byte after reset
        idle_cycles(2, "R2");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule